// File: doc/BRIEF.md
# Multicore Local Interrupt Router

This block sits between the interrupt sources of a four-core cluster and the cores themselves. Every core owns four local timer interrupt lines and four mailbox-pending flags, which arrive from a separate mailbox bank. Two shared upstream lines, one IRQ and one FIQ, come from the system interrupt controller. For every core the block drives one IRQ output and one FIQ output.

Per-core enable registers decide, for each local source, whether it reaches the core as a fast interrupt, as a normal interrupt, or not at all. A fast-interrupt enable always takes precedence. A routing register sends the upstream IRQ to one chosen core and the upstream FIQ to one chosen core. Software sets up the block and inspects it through a small 32-bit register bus. On that bus, read-only per-core source registers show which sources are currently asserting each output.

The source registers and the core outputs are pure combinational logic. They are driven by the live inputs and the stored controls.

Top module: `core_irq_router`

## Requirements
- R1: After reset the routing register, all timer control registers and all mailbox control registers read zero. In this state an active upstream IRQ reaches core 0.
- R2: The routing register is at address 0x0C. Bits [1:0] select the core that receives the upstream IRQ, and bits [3:2] select the core that receives the upstream FIQ. A read returns the same packing, with all higher bits zero.
- R3: The upstream IRQ sets bit 8 of the IRQ source register of exactly the selected core, and of no other core. The upstream FIQ sets bit 8 of the FIQ source register of its selected core in the same way.
- R4: The timer control register of core c is at address 0x40+4c. It keeps bits [7:0] of the write data, and a read returns zero in bits [31:8]. Bit j is the IRQ enable of timer line j, and bit 4+j is its FIQ enable.
- R5: The mailbox control register of core c is at address 0x50+4c. It has the same 8-bit storage and layout: bit j enables mailbox j to IRQ, and bit 4+j enables it to FIQ.
- R6: An active local source is routed by priority. If its FIQ enable is set, it appears only in the FIQ source register. Otherwise, if its IRQ enable is set, it appears only in the IRQ source register. If neither enable is set, it appears in neither.
- R7: Source register bit positions are fixed. Bits 0 to 3 are timer lines 0 to 3 of that core, whose input index is 4c+j. Bits 4 to 7 are mailboxes 0 to 3, whose pending input index is 4c+j. Bit 8 is the upstream line. Bits 9 and above always read zero.
- R8: The IRQ source register of core c is at 0x60+4c, and the FIQ source register is at 0x70+4c. Both are read-only, so writes to them change nothing. Their contents always follow the current inputs: when an input drops, its bit clears.
- R9: A core's IRQ output is high exactly when that core's IRQ source register is nonzero. The same rule links each FIQ output to its FIQ source register.
- R10: Addresses outside the mapped registers read as zero, and writes to them change no register. Addresses that are not a multiple of four count as unmapped.
- R11: A change on an interrupt input shows at the core outputs in the same cycle. A control write shows in the cycle after the write. Read data appears in the cycle after the read request, and is zero in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| timer_irq_i | input | 16 | Local timer lines, core c line j at index 4c+j |
| mbox_pend_i | input | 16 | Mailbox-pending flags, core c mailbox j at index 4c+j |
| up_irq_i | input | 1 | Shared upstream IRQ |
| up_fiq_i | input | 1 | Shared upstream FIQ |
| bus_valid_i | input | 1 | Bus request valid |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the read request |
| core_irq_o | output | 4 | IRQ output per core |
| core_fiq_o | output | 4 | FIQ output per core |

## Verification
The assertions assume that interrupt and bus inputs are known after reset and that a read request is never issued in the same cycle as a write. The routing-readback property relies on this: it takes the routing state from the cycle of the read. The single-core property for the upstream IRQ also assumes that all four cores exist, so every 2-bit selector value names a real core. The bench meets these assumptions as follows:
- It drives every input from reset onward.
- It issues one bus transaction at a time, each changing at a falling edge.
- It changes interrupt lines only between transactions.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int ROUTE_W = 2;

  // address map: group = addr[7:4], index = addr[3:2]
  localparam logic [3:0] GRP_MISC = 4'h0;
  localparam logic [3:0] GRP_TCTL = 4'h4;
  localparam logic [3:0] GRP_MCTL = 4'h5;
  localparam logic [3:0] GRP_ISRC = 4'h6;
  localparam logic [3:0] GRP_FSRC = 4'h7;
  localparam logic [1:0] IDX_ROUTE = 2'd3;

  typedef struct packed {
    logic [ROUTE_W-1:0] fiq_core;
    logic [ROUTE_W-1:0] irq_core;
  } route_t;
endpackage

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_router_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CTL_W     = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [CTL_W-1:0]                  wdata_i,
  output route_t                            route_o,
  output logic [NUM_CORES-1:0][CTL_W-1:0]   tctl_o,
  output logic [NUM_CORES-1:0][CTL_W-1:0]   mctl_o
);
  logic       aligned;
  logic [3:0] grp;
  logic [1:0] idx;
  logic       wr_route;

  assign aligned  = (addr_i[1:0] == 2'b00);
  assign grp      = addr_i[7:4];
  assign idx      = addr_i[3:2];
  assign wr_route = wr_en_i && aligned && (grp == GRP_MISC) && (idx == IDX_ROUTE);

  route_t route_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       route_q <= '0;
    else if (wr_route) route_q <= route_t'(wdata_i[2*ROUTE_W-1:0]);
  end

  assign route_o = route_q;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic wr_t, wr_m;
    logic [CTL_W-1:0] tctl_q, mctl_q;

    assign wr_t = wr_en_i && aligned && (grp == GRP_TCTL) && (idx == 2'(c));
    assign wr_m = wr_en_i && aligned && (grp == GRP_MCTL) && (idx == 2'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tctl_q <= '0;
        mctl_q <= '0;
      end else begin
        if (wr_t) tctl_q <= wdata_i;
        if (wr_m) mctl_q <= wdata_i;
      end
    end

    assign tctl_o[c] = tctl_q;
    assign mctl_o[c] = mctl_q;
  end
endmodule

// File: rtl/irq_core_src.sv
module irq_core_src #(
  parameter int LINES = 4,
  parameter int SRC_W = 12
) (
  input  logic [LINES-1:0]   timer_i,
  input  logic [LINES-1:0]   mbox_i,
  input  logic [2*LINES-1:0] tctl_i,
  input  logic [2*LINES-1:0] mctl_i,
  input  logic               up_irq_i,
  input  logic               up_fiq_i,
  output logic [SRC_W-1:0]   irq_src_o,
  output logic [SRC_W-1:0]   fiq_src_o
);
  localparam int UP_BIT = 2 * LINES;

  logic [LINES-1:0] t_fiq, t_irq, m_fiq, m_irq;

  // FIQ enable wins over IRQ enable
  assign t_fiq = timer_i & tctl_i[2*LINES-1:LINES];
  assign t_irq = timer_i & tctl_i[LINES-1:0] & ~tctl_i[2*LINES-1:LINES];
  assign m_fiq = mbox_i  & mctl_i[2*LINES-1:LINES];
  assign m_irq = mbox_i  & mctl_i[LINES-1:0] & ~mctl_i[2*LINES-1:LINES];

  always_comb begin
    irq_src_o = '0;
    fiq_src_o = '0;
    irq_src_o[LINES-1:0]       = t_irq;
    irq_src_o[2*LINES-1:LINES] = m_irq;
    irq_src_o[UP_BIT]          = up_irq_i;
    fiq_src_o[LINES-1:0]       = t_fiq;
    fiq_src_o[2*LINES-1:LINES] = m_fiq;
    fiq_src_o[UP_BIT]          = up_fiq_i;
  end
endmodule

// File: rtl/core_irq_router.sv
module core_irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int LINES     = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_CORES*LINES-1:0] timer_irq_i,
  input  logic [NUM_CORES*LINES-1:0] mbox_pend_i,
  input  logic                       up_irq_i,
  input  logic                       up_fiq_i,
  input  logic                       bus_valid_i,
  input  logic                       bus_write_i,
  input  logic [ADDR_W-1:0]          bus_addr_i,
  input  logic [DATA_W-1:0]          bus_wdata_i,
  output logic [DATA_W-1:0]          bus_rdata_o,
  output logic [NUM_CORES-1:0]       core_irq_o,
  output logic [NUM_CORES-1:0]       core_fiq_o
);
  localparam int CTL_W = 2 * LINES;
  localparam int SRC_W = 2 * LINES + 4; // upstream bit + 3 reserved

  route_t                          route;
  logic [NUM_CORES-1:0][CTL_W-1:0] tctl, mctl;
  logic [NUM_CORES-1:0][SRC_W-1:0] irq_src, fiq_src;
  logic                            unused_wdata;

  assign unused_wdata = ^bus_wdata_i[DATA_W-1:CTL_W];

  irq_ctrl_regs #(
    .NUM_CORES(NUM_CORES),
    .CTL_W    (CTL_W)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(bus_valid_i && bus_write_i),
    .addr_i (bus_addr_i),
    .wdata_i(bus_wdata_i[CTL_W-1:0]),
    .route_o(route),
    .tctl_o (tctl),
    .mctl_o (mctl)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic up_irq_hit, up_fiq_hit;
    assign up_irq_hit = up_irq_i && (route.irq_core == ROUTE_W'(c));
    assign up_fiq_hit = up_fiq_i && (route.fiq_core == ROUTE_W'(c));

    irq_core_src #(
      .LINES(LINES),
      .SRC_W(SRC_W)
    ) u_src (
      .timer_i  (timer_irq_i[c*LINES +: LINES]),
      .mbox_i   (mbox_pend_i[c*LINES +: LINES]),
      .tctl_i   (tctl[c]),
      .mctl_i   (mctl[c]),
      .up_irq_i (up_irq_hit),
      .up_fiq_i (up_fiq_hit),
      .irq_src_o(irq_src[c]),
      .fiq_src_o(fiq_src[c])
    );

    assign core_irq_o[c] = |irq_src[c];
    assign core_fiq_o[c] = |fiq_src[c];
  end

  // read mux
  logic [DATA_W-1:0] rd_val;
  logic [3:0]        rd_grp;
  logic [1:0]        rd_idx;

  assign rd_grp = bus_addr_i[7:4];
  assign rd_idx = bus_addr_i[3:2];

  always_comb begin
    rd_val = '0;
    if (bus_addr_i[1:0] == 2'b00) begin
      if (rd_grp == GRP_MISC && rd_idx == IDX_ROUTE) rd_val = DATA_W'(route);
      for (int c = 0; c < NUM_CORES; c++) begin
        if (rd_idx == 2'(c)) begin
          unique case (rd_grp)
            GRP_TCTL: rd_val = DATA_W'(tctl[c]);
            GRP_MCTL: rd_val = DATA_W'(mctl[c]);
            GRP_ISRC: rd_val = DATA_W'(irq_src[c]);
            GRP_FSRC: rd_val = DATA_W'(fiq_src[c]);
            default:  ;
          endcase
        end
      end
    end
  end

  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         rdata_q <= '0;
    else if (bus_valid_i && !bus_write_i) rdata_q <= rd_val;
    else                                 rdata_q <= '0;
  end

  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/irq_router_checker.sv
module irq_router_checker
  import irq_router_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int LINES     = 4
) (
  input logic                                clk_i,
  input logic                                rst_ni,
  input logic [NUM_CORES*LINES-1:0]          timer_irq_i,
  input logic [NUM_CORES*LINES-1:0]          mbox_pend_i,
  input logic                                up_irq_i,
  input logic                                up_fiq_i,
  input logic                                bus_valid_i,
  input logic                                bus_write_i,
  input logic [ADDR_W-1:0]                   bus_addr_i,
  input logic [DATA_W-1:0]                   bus_rdata_o,
  input logic [NUM_CORES-1:0]                core_irq_o,
  input logic [NUM_CORES-1:0]                core_fiq_o,
  input route_t                              route,
  input logic [NUM_CORES-1:0][2*LINES-1:0]   tctl,
  input logic [NUM_CORES-1:0][2*LINES-1:0]   mctl
);
  logic ctl_addr;
  assign ctl_addr = (bus_addr_i == 8'h0C) ||
                    ((bus_addr_i[1:0] == 2'b00) &&
                     (bus_addr_i[7:4] == GRP_TCTL || bus_addr_i[7:4] == GRP_MCTL) &&
                     (int'(bus_addr_i[3:2]) < NUM_CORES));

  assert_up_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timer_irq_i == '0 && mbox_pend_i == '0) |-> ($countones(core_irq_o) == int'(up_irq_i)));

  assert_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tctl == '0 && mctl == '0 && !up_irq_i && !up_fiq_i) |-> (core_irq_o == '0 && core_fiq_o == '0));

  assert_rdata_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bus_valid_i && !bus_write_i) |-> (bus_rdata_o == '0));

  assert_rdata_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[DATA_W-1:2*LINES+1] == '0);

  assert_ignored_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_write_i && !ctl_addr) |=> ($stable(route) && $stable(tctl) && $stable(mctl)));

  assert_route_rd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && !bus_write_i && bus_addr_i == 8'h0C) |=>
      (bus_rdata_o[3:0] == {$past(route.fiq_core), $past(route.irq_core)}));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_prio
    assert_fiq_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|((timer_irq_i[c*LINES +: LINES] & tctl[c][2*LINES-1:LINES]) |
         (mbox_pend_i[c*LINES +: LINES] & mctl[c][2*LINES-1:LINES]))) |-> core_fiq_o[c]);
  end
endmodule

bind core_irq_router irq_router_checker #(
  .NUM_CORES(NUM_CORES),
  .LINES    (LINES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .timer_irq_i(timer_irq_i),
  .mbox_pend_i(mbox_pend_i),
  .up_irq_i   (up_irq_i),
  .up_fiq_i   (up_fiq_i),
  .bus_valid_i(bus_valid_i),
  .bus_write_i(bus_write_i),
  .bus_addr_i (bus_addr_i),
  .bus_rdata_o(bus_rdata_o),
  .core_irq_o (core_irq_o),
  .core_fiq_o (core_fiq_o),
  .route      (route),
  .tctl       (tctl),
  .mctl       (mctl)
);

// File: tb/sim_core_irq_router.sv
module sim_core_irq_router;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] timer_irq = '0;
  logic [15:0] mbox_pend = '0;
  logic        up_irq = 1'b0;
  logic        up_fiq = 1'b0;
  logic        valid = 1'b0;
  logic        write = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq_o, fiq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  core_irq_router u0 (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .timer_irq_i(timer_irq),
    .mbox_pend_i(mbox_pend),
    .up_irq_i   (up_irq),
    .up_fiq_i   (up_fiq),
    .bus_valid_i(valid),
    .bus_write_i(write),
    .bus_addr_i (addr),
    .bus_wdata_i(wdata),
    .bus_rdata_o(rdata),
    .core_irq_o (irq_o),
    .core_fiq_o (fiq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b0; addr = a;
    @(negedge clk);
    valid = 1'b0;
    d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic clear_all();
    timer_irq = '0; mbox_pend = '0; up_irq = 1'b0; up_fiq = 1'b0;
    for (int c = 0; c < 4; c++) begin
      bus_wr(8'h40 + 8'(4*c), 32'h0);
      bus_wr(8'h50 + 8'(4*c), 32'h0);
    end
    bus_wr(8'h0C, 32'h0);
  endtask

  task automatic t_reset();
    rd_chk("R1 route", 8'h0C, 32'h0);
    for (int c = 0; c < 4; c++) begin
      rd_chk("R1 tctl", 8'h40 + 8'(4*c), 32'h0);
      rd_chk("R1 mctl", 8'h50 + 8'(4*c), 32'h0);
    end
    #1;
    chk("R1 idle irq", {28'h0, irq_o}, 32'h0);
    chk("R1 idle fiq", {28'h0, fiq_o}, 32'h0);
    chk("R11 rdata idle", rdata, 32'h0);
    @(negedge clk); up_irq = 1'b1; #1;
    chk("R1 up to core0", {28'h0, irq_o}, 32'h1);
    up_irq = 1'b0;
  endtask

  task automatic t_route();
    bus_wr(8'h0C, 32'hFFFF_FFF6);
    rd_chk("R2 readback", 8'h0C, 32'h6);
    @(negedge clk); up_irq = 1'b1; #1;
    chk("R3 irq core2", {28'h0, irq_o}, 32'h4);
    chk("R3 no fiq", {28'h0, fiq_o}, 32'h0);
    rd_chk("R3 isrc core2", 8'h68, 32'h100);
    rd_chk("R3 isrc core0", 8'h60, 32'h0);
    @(negedge clk); up_irq = 1'b0; up_fiq = 1'b1; #1;
    chk("R3 fiq core1", {28'h0, fiq_o}, 32'h2);
    rd_chk("R3 fsrc core1", 8'h74, 32'h100);
    up_fiq = 1'b0;
    clear_all();
  endtask

  task automatic t_ctl();
    bus_wr(8'h44, 32'hABCD_12A5);
    rd_chk("R4 tctl core1", 8'h44, 32'hA5);
    bus_wr(8'h5C, 32'h0000_013C);
    rd_chk("R5 mctl core3", 8'h5C, 32'h3C);
    rd_chk("R5 mctl core2", 8'h58, 32'h0);
    clear_all();
  endtask

  task automatic t_prio();
    // core1 timers: IRQ en 0,1; FIQ en 0; line 2 masked
    bus_wr(8'h44, 32'h13);
    // core3 mailboxes: IRQ en mb2, FIQ en mb3
    bus_wr(8'h5C, 32'h84);
    @(negedge clk);
    timer_irq = 16'h0070;
    mbox_pend = 16'hC00F;
    #1;
    chk("R9 irq out", {28'h0, irq_o}, 32'hA);
    chk("R9 fiq out", {28'h0, fiq_o}, 32'hA);
    rd_chk("R6 isrc core1", 8'h64, 32'h002);
    rd_chk("R6 fsrc core1", 8'h74, 32'h001);
    rd_chk("R7 isrc core3", 8'h6C, 32'h040);
    rd_chk("R7 fsrc core3", 8'h7C, 32'h080);
    rd_chk("R6 masked core0", 8'h60, 32'h0);
    clear_all();
  endtask

  task automatic t_live();
    bus_wr(8'h40, 32'h01);
    @(negedge clk); timer_irq = 16'h0001; #1;
    chk("R11 same cycle", {28'h0, irq_o}, 32'h1);
    bus_wr(8'h60, 32'hFFFF_FFFF);
    bus_wr(8'h70, 32'hFFFF_FFFF);
    rd_chk("R8 isrc after wr", 8'h60, 32'h1);
    rd_chk("R8 fsrc after wr", 8'h70, 32'h0);
    @(negedge clk); timer_irq = '0; #1;
    chk("R9 irq drops", {28'h0, irq_o}, 32'h0);
    rd_chk("R8 isrc cleared", 8'h60, 32'h0);
    bus_wr(8'h40, 32'h10);
    @(negedge clk); timer_irq = 16'h0001; #1;
    chk("R11 ctl then fiq", {28'h0, fiq_o}, 32'h1);
    clear_all();
  endtask

  task automatic t_unmapped();
    bus_wr(8'h44, 32'h5A);
    bus_wr(8'h00, 32'hFF);
    bus_wr(8'h30, 32'hFF);
    bus_wr(8'h46, 32'hFF);
    bus_wr(8'h0E, 32'hFF);
    rd_chk("R10 tctl kept", 8'h44, 32'h5A);
    rd_chk("R10 route kept", 8'h0C, 32'h0);
    rd_chk("R10 rd 0x00", 8'h00, 32'h0);
    rd_chk("R10 rd 0x80", 8'h80, 32'h0);
    rd_chk("R10 rd misaligned", 8'h45, 32'h0);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_route();
    t_ctl();
    t_prio();
    t_live();
    t_unmapped();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule